// File: doc/BRIEF.md
# Asynchronous SRAM Bus Protocol Monitor

This block watches the control side of an asynchronous 16-bit static RAM bus and reports protocol faults. A fast clock samples every pin, so each pin is seen as a sequence of samples. The sampled pins are the word address, the active-low chip enable, write enable and output enable, the two active-low byte selects, and one flag that is high while the controller drives the data bus. The block only observes. It never changes the bus.

A write is open only while chip enable and write enable are both low. The later of the two falling edges opens the write, and the earlier rising edge closes it. The block measures several things in samples: how long each write stays open, how far apart successive writes start, how long the data was driven before the write closed, and how long the address holds after the close. It compares each figure with a minimum set by a parameter. It also checks that the address stays fixed while write enable is low. Finally, it flags any sample in which the controller drives the bus while the memory is presenting read data.

There is one report per rule. A one-cycle pulse marks each offending sample, and a sticky bit records the fault until a synchronous clear. The inputs are assumed to be synchronous to the sample clock already, and nothing is checked during reset.

Top module: `sram_bus_monitor`

## Requirements
- R1: While reset is asserted and right after it is released, every sticky bit and every pulse bit is 0.
- R2: Rule bit 0 (address hold) is flagged when write enable is low in two successive samples and the address differs between them. The first sample after reset is never flagged.
- R3: Rule bit 1 (write pulse). A write is open in each sample where both chip enable and write enable are low. This holds whichever of the two fell last. In the first sample where the write is no longer open, the bit is flagged if it was open in fewer than MIN_WP samples.
- R4: Rule bit 2 (write cycle) is flagged when a write opens fewer than MIN_WC samples after the previous write opened.
- R5: Rule bit 3 (data setup) is flagged in the sample where a write closes, if the data flag was high in fewer than MIN_DW consecutive samples just before that sample.
- R6: Rule bit 4 (contention) is flagged in every sample with chip enable low, output enable low, write enable high, at least one byte select low and the data flag high. With write enable low, or with both byte selects high, the bit is not flagged.
- R7: Rule bit 5 (recovery) is flagged when the address changes in the sample where a write closes, or fewer than MIN_WR samples after that sample.
- R8: A violation in the sample taken at one clock edge appears on errPulse right after that edge, for that one cycle only, and sets the matching errSticky bit at the same moment.
- R9: A sticky bit stays set until clearErr is sampled high. The clear takes effect at that same edge. A violation found at the same edge as the clear stays set.
- R10: A write that keeps every minimum and holds its address raises no bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clearErr | input | 1 | Synchronous clear of all sticky bits |
| addr | input | ADDR_W | Sampled word address |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| lbN | input | 1 | Low byte select, active low |
| ubN | input | 1 | High byte select, active low |
| busDrive | input | 1 | High while the controller drives the data bus |
| errSticky | output | 6 | Per-rule sticky fault bits, indexed as in R2 to R7 |
| errPulse | output | 6 | Per-rule one-cycle fault pulses |

## Verification
The case where two functions meet in one cycle is a sticky clear arriving in the same sample as a new violation. The bench first leaves an address-hold fault in the sticky bits. It then holds clearErr high in the one sample where the controller drives the bus against a read. After that edge, only the contention bit may remain. Both the per-cycle reference model and a directed check judge this. A second overlap is a write that closes while the address changes: the bench requires that this raises the recovery bit only, and not the address-hold bit.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;

  localparam int RULE_ADDR_HOLD   = 0;
  localparam int RULE_WRITE_PULSE = 1;
  localparam int RULE_WRITE_CYCLE = 2;
  localparam int RULE_DATA_SETUP  = 3;
  localparam int RULE_CONTENTION  = 4;
  localparam int RULE_RECOVERY    = 5;
  localparam int NUM_RULES        = 6;

  // Strobes passed from the control module to the datapath each sample.
  typedef struct packed {
    logic winOpen;    // chip enable and write enable both low
    logic winStart;   // write window opened in this sample
    logic winEnd;     // write window closed in this sample
    logic addrMoved;  // address differs from the previous sample
    logic weHeld;     // write enable low in this and the previous sample
    logic memDrives;  // memory is presenting read data
    logic ctlDrives;  // controller drives the data bus
  } monStrobes_t;

endpackage

// File: rtl/sram_mon_span.sv
// Saturating sample counter with a below-limit flag.
module sram_mon_span #(
  parameter int MAX_COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seed,   // restart counting at one
  input  logic drop,   // return to zero
  input  logic step,   // advance by one, saturating at MAX_COUNT
  output logic below   // count is under MAX_COUNT
);

  localparam int CW = $clog2(MAX_COUNT + 2);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_COUNT);

  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (seed) begin
      count <= CW'(1);
    end else if (drop) begin
      count <= '0;
    end else if (step && (count < LIMIT)) begin
      count <= count + 1'b1;
    end
  end

  assign below = (count < LIMIT);

endmodule

// File: rtl/sram_mon_ctrl.sv
// Edge and state decode of the sampled bus pins.
module sram_mon_ctrl
  import sram_mon_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              lbN,
  input  logic              ubN,
  input  logic              busDrive,
  output monStrobes_t       strobes
);

  logic [ADDR_W-1:0] prevAddr;
  logic              prevWin;
  logic              prevWeN;
  logic              primed;
  logic              winNow;

  assign winNow = ~ceN & ~weN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevAddr <= '0;
      prevWin  <= 1'b0;
      prevWeN  <= 1'b1;
      primed   <= 1'b0;
    end else begin
      prevAddr <= addr;
      prevWin  <= winNow;
      prevWeN  <= weN;
      primed   <= 1'b1;
    end
  end

  always_comb begin
    strobes.winOpen   = winNow;
    strobes.winStart  = winNow & ~prevWin;
    strobes.winEnd    = ~winNow & prevWin;
    strobes.addrMoved = primed & (addr != prevAddr);
    strobes.weHeld    = ~weN & ~prevWeN;
    strobes.memDrives = ~ceN & ~oeN & weN & (~lbN | ~ubN);
    strobes.ctlDrives = busDrive;
  end

endmodule

// File: rtl/sram_mon_datapath.sv
// Interval measurement, rule evaluation and fault registers.
module sram_mon_datapath
  import sram_mon_pkg::*;
#(
  parameter int MIN_WC = 6,
  parameter int MIN_WP = 3,
  parameter int MIN_DW = 3,
  parameter int MIN_WR = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clearErr,
  input  monStrobes_t          strobes,
  output logic [NUM_RULES-1:0] errSticky,
  output logic [NUM_RULES-1:0] errPulse
);

  localparam logic CHECK_REC = (MIN_WR > 0);

  logic wpShort, wcShort, dwShort, recShort;
  logic seenStart, seenEnd;
  logic [NUM_RULES-1:0] viol;

  // Samples the current write window has been open.
  sram_mon_span #(.MAX_COUNT(MIN_WP)) u_wpSpan (
    .clk(clk), .rst_n(rst_n),
    .seed(strobes.winStart), .drop(1'b0), .step(strobes.winOpen),
    .below(wpShort)
  );

  // Samples since the last window opened.
  sram_mon_span #(.MAX_COUNT(MIN_WC)) u_wcSpan (
    .clk(clk), .rst_n(rst_n),
    .seed(strobes.winStart), .drop(1'b0), .step(1'b1),
    .below(wcShort)
  );

  // Consecutive samples with the controller driving data.
  sram_mon_span #(.MAX_COUNT(MIN_DW)) u_dwSpan (
    .clk(clk), .rst_n(rst_n),
    .seed(1'b0), .drop(~strobes.ctlDrives), .step(strobes.ctlDrives),
    .below(dwShort)
  );

  // Samples since the last window closed.
  sram_mon_span #(.MAX_COUNT(MIN_WR)) u_recSpan (
    .clk(clk), .rst_n(rst_n),
    .seed(strobes.winEnd), .drop(1'b0), .step(1'b1),
    .below(recShort)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seenStart <= 1'b0;
      seenEnd   <= 1'b0;
    end else begin
      seenStart <= seenStart | strobes.winStart;
      seenEnd   <= seenEnd | strobes.winEnd;
    end
  end

  always_comb begin
    viol = '0;
    viol[RULE_ADDR_HOLD]   = strobes.weHeld & strobes.addrMoved;
    viol[RULE_WRITE_PULSE] = strobes.winEnd & wpShort;
    viol[RULE_WRITE_CYCLE] = strobes.winStart & seenStart & wcShort;
    viol[RULE_DATA_SETUP]  = strobes.winEnd & dwShort;
    viol[RULE_CONTENTION]  = strobes.memDrives & strobes.ctlDrives;
    viol[RULE_RECOVERY]    = strobes.addrMoved &
                             ((strobes.winEnd & CHECK_REC) | (seenEnd & recShort));
  end

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        errPulse[r]  <= 1'b0;
        errSticky[r] <= 1'b0;
      end else begin
        errPulse[r]  <= viol[r];
        errSticky[r] <= (errSticky[r] & ~clearErr) | viol[r];
      end
    end
  end

endmodule

// File: rtl/sram_bus_monitor.sv
module sram_bus_monitor
  import sram_mon_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int MIN_WC = 6,
  parameter int MIN_WP = 3,
  parameter int MIN_DW = 3,
  parameter int MIN_WR = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clearErr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 ceN,
  input  logic                 weN,
  input  logic                 oeN,
  input  logic                 lbN,
  input  logic                 ubN,
  input  logic                 busDrive,
  output logic [NUM_RULES-1:0] errSticky,
  output logic [NUM_RULES-1:0] errPulse
);

  monStrobes_t strobes;

  sram_mon_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .ceN(ceN), .weN(weN), .oeN(oeN), .lbN(lbN), .ubN(ubN),
    .busDrive(busDrive), .strobes(strobes)
  );

  sram_mon_datapath #(
    .MIN_WC(MIN_WC), .MIN_WP(MIN_WP), .MIN_DW(MIN_DW), .MIN_WR(MIN_WR)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .clearErr(clearErr), .strobes(strobes),
    .errSticky(errSticky), .errPulse(errPulse)
  );

endmodule

// File: rtl/sram_bus_monitor_chk.sv
module sram_bus_monitor_chk
  import sram_mon_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clearErr,
  input logic [ADDR_W-1:0]    addr,
  input logic                 ceN,
  input logic                 weN,
  input logic                 oeN,
  input logic                 lbN,
  input logic                 ubN,
  input logic                 busDrive,
  input logic [NUM_RULES-1:0] errSticky,
  input logic [NUM_RULES-1:0] errPulse
);

  logic pastValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pastValid <= 1'b0;
    else        pastValid <= 1'b1;
  end

  // R2: the address moving under a held write enable is reported.
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && !weN && !$past(weN) && (addr != $past(addr))) |=> errPulse[RULE_ADDR_HOLD]);

  // R6: driving against read data is reported.
  assert_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ceN && !oeN && weN && (!lbN || !ubN) && busDrive) |=> errPulse[RULE_CONTENTION]);

  // R8: every pulse is mirrored in the sticky bits.
  assert_pulse_sets_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|errPulse) |-> ((errSticky & errPulse) == errPulse));

  // R9: without a clear, no sticky bit falls.
  assert_sticky_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && !clearErr) |=> ((errSticky & $past(errSticky)) == $past(errSticky)));

  // R9: after a clear only fresh violations remain.
  assert_clear_leaves_fresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clearErr |=> (errSticky == errPulse));

endmodule

bind sram_bus_monitor sram_bus_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clearErr(clearErr), .addr(addr),
  .ceN(ceN), .weN(weN), .oeN(oeN), .lbN(lbN), .ubN(ubN),
  .busDrive(busDrive), .errSticky(errSticky), .errPulse(errPulse)
);

// File: tb/tb_sram_bus_monitor.sv
`timescale 1ns/1ps
module tb_sram_bus_monitor;

  localparam int ADDR_W = 18;
  localparam int MIN_WC = 6;
  localparam int MIN_WP = 3;
  localparam int MIN_DW = 3;
  localparam int MIN_WR = 1;
  localparam int NR     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clearErr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, lbN = 1'b0, ubN = 1'b0, busDrive = 1'b0;
  logic [NR-1:0] errSticky, errPulse;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sram_bus_monitor #(
    .ADDR_W(ADDR_W), .MIN_WC(MIN_WC), .MIN_WP(MIN_WP), .MIN_DW(MIN_DW), .MIN_WR(MIN_WR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .clearErr(clearErr), .addr(addr),
    .ceN(ceN), .weN(weN), .oeN(oeN), .lbN(lbN), .ubN(ubN),
    .busDrive(busDrive), .errSticky(errSticky), .errPulse(errPulse)
  );

  // ---------------- behavioural reference model ----------------
  bit mPrimed;
  logic [ADDR_W-1:0] mPrevAddr;
  bit mPrevWe, mPrevWin;
  int winLen, sinceStart, driveRun, sinceEnd;
  logic [NR-1:0] expPulse, expSticky;

  function automatic string ruleTag(int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPrimed = 0; mPrevAddr = '0; mPrevWe = 1; mPrevWin = 0;
      winLen = 0; sinceStart = -1; driveRun = 0; sinceEnd = 1000;
      expPulse = '0; expSticky = '0;
    end else begin
      logic [NR-1:0] v;
      bit win, opened, closed, moved;
      v = '0;
      win    = !ceN && !weN;
      opened = win && !mPrevWin;
      closed = !win && mPrevWin;
      moved  = mPrimed && (addr != mPrevAddr);
      if (sinceStart >= 0) sinceStart++;
      if (sinceEnd < 1000) sinceEnd++;
      v[0] = moved && !weN && !mPrevWe;
      v[1] = closed && (winLen < MIN_WP);
      v[2] = opened && (sinceStart >= 0) && (sinceStart < MIN_WC);
      v[3] = closed && (driveRun < MIN_DW);
      v[4] = !ceN && !oeN && weN && (!lbN || !ubN) && busDrive;
      v[5] = moved && ((closed && MIN_WR > 0) || (sinceEnd < MIN_WR));
      if (opened) begin winLen = 0; sinceStart = 0; end
      if (win) winLen++;
      if (closed) sinceEnd = 0;
      driveRun = busDrive ? driveRun + 1 : 0;
      expSticky = (clearErr ? '0 : expSticky) | v;
      expPulse  = v;
      mPrimed = 1; mPrevAddr = addr; mPrevWe = weN; mPrevWin = win;
    end
  end

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      checks += 2;
      if (errPulse !== expPulse) begin
        errors++;
        for (int i = 0; i < NR; i++)
          if (errPulse[i] !== expPulse[i])
            $display("FAIL %s/R8 pulse bit %0d: actual=%b expected=%b at %0t",
                     ruleTag(i), i, errPulse[i], expPulse[i], $time);
      end
      if (errSticky !== expSticky) begin
        errors++;
        $display("FAIL R9 sticky: actual=%b expected=%b at %0t", errSticky, expSticky, $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    ceN = 1; weN = 1; oeN = 1; lbN = 0; ubN = 0; busDrive = 0; clearErr = 0;
  endtask

  task automatic check(string tag, logic [NR-1:0] act, logic [NR-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clearAll();
    clearErr = 1; cyc(1); clearErr = 0; cyc(1);
  endtask

  // Window of wlen samples, data driven for all of them and before.
  task automatic goodWrite(logic [ADDR_W-1:0] a, int wlen);
    addr = a; busDrive = 1; ceN = 0; cyc(1);
    weN = 0; cyc(wlen);
    weN = 1; cyc(1);
    ceN = 1; busDrive = 0; cyc(1);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    idle();
    cyc(3);
    check("R1 sticky during reset", errSticky, '0);
    check("R1 pulse during reset", errPulse, '0);
    rst_n = 1;
    cyc(1);
    check("R1 sticky after reset", errSticky, '0);

    // R10: compliant writes, spaced wide apart
    goodWrite(18'h00100, 4);
    cyc(8);
    goodWrite(18'h00200, 3);
    cyc(8);
    check("R10 compliant writes", errSticky, '0);

    // R3: short write-enable controlled pulse
    addr = 18'h00300; busDrive = 1; ceN = 0; cyc(4);
    weN = 0; cyc(2);
    weN = 1; cyc(1);
    idle(); cyc(2);
    check("R3 short WE window", errSticky, 6'b000010);
    clearAll(); cyc(6);

    // R3: chip-enable controlled window (CE falls last, rises first)
    addr = 18'h00310; busDrive = 1; weN = 0; cyc(4);
    ceN = 0; cyc(2);
    ceN = 1; cyc(1);
    weN = 1; idle(); cyc(2);
    check("R3 short CE window", errSticky, 6'b000010);
    clearAll(); cyc(6);

    // R4: two windows opening 4 samples apart
    addr = 18'h00400; busDrive = 1; ceN = 0; cyc(3);
    weN = 0; cyc(3);
    weN = 1; cyc(1);
    weN = 0; cyc(3);
    weN = 1; cyc(1);
    idle(); cyc(2);
    check("R4 write cycle too short", errSticky, 6'b000100);
    clearAll(); cyc(8);

    // R5: data driven only in the last open sample
    addr = 18'h00500; ceN = 0; cyc(1);
    weN = 0; cyc(3);
    busDrive = 1; cyc(1);
    weN = 1; cyc(1);
    idle(); cyc(2);
    check("R5 data setup too short", errSticky, 6'b001000);
    clearAll(); cyc(8);

    // R2: address moves while write enable is held low
    addr = 18'h00600; busDrive = 1; ceN = 0; cyc(3);
    weN = 0; cyc(2);
    addr = 18'h00601; cyc(2);
    weN = 1; cyc(1);
    idle(); cyc(2);
    check("R2 address change under WE", errSticky, 6'b000001);
    clearAll(); cyc(8);

    // R7: address changes in the very sample the write closes
    addr = 18'h00700; busDrive = 1; ceN = 0; cyc(3);
    weN = 0; cyc(4);
    weN = 1; addr = 18'h00701; cyc(1);
    idle(); cyc(2);
    check("R7 recovery violated", errSticky, 6'b100000);
    clearAll(); cyc(8);

    // R6: contention on a read, with one pulse of one cycle (R8)
    addr = 18'h00800; ceN = 0; oeN = 0; cyc(2);
    busDrive = 1; cyc(1);
    check("R8 pulse right after offending edge", errPulse, 6'b010000);
    busDrive = 0; cyc(1);
    check("R8 pulse lasts one cycle", errPulse, 6'b000000);
    idle(); cyc(2);
    check("R6 contention flagged", errSticky, 6'b010000);
    clearAll();

    // R6: no contention with both byte selects high
    ceN = 0; oeN = 0; lbN = 1; ubN = 1; busDrive = 1; cyc(3);
    idle(); cyc(2);
    check("R6 no contention with bytes off", errSticky, 6'b000000);
    cyc(6);

    // R9: clear coincides with a fresh contention sample
    addr = 18'h00900; busDrive = 1; ceN = 0; cyc(3);
    weN = 0; cyc(2);
    addr = 18'h00901; cyc(2);
    weN = 1; cyc(1);
    idle(); cyc(2);
    check("R9 setup sticky", errSticky, 6'b000001);
    cyc(3);
    check("R9 sticky holds", errSticky, 6'b000001);
    ceN = 0; oeN = 0; busDrive = 1; clearErr = 1; cyc(1);
    check("R9 clear with coincident violation", errSticky, 6'b010000);
    idle(); cyc(2);
    clearAll();
    check("R9 clear empties", errSticky, 6'b000000);

    cyc(4);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule